// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Group Sequencer

This block controls a shared successive-approximation converter that sits behind a four-channel track/hold front end. Three phase channels (U, V, W) and one auxiliary slot are held at the same instant. They are then digitized one after another. A start strobe begins a group. The sequencer times the acquisition window, walks a channel-select code through the channels the mode enables, and captures one 11-bit sample per channel from a fixed-latency converter data port. Each sample is stored as a left-justified 12-bit two's-complement word in that channel's result register.

Two mode bits pick the channel group, and a 2-bit field picks which of four auxiliary inputs feeds the auxiliary slot. A re-acquisition interval follows every group and also follows reset. A start strobe that arrives during this interval is remembered and acted on as soon as the interval ends. A strobe that arrives while a group is running is discarded. When a group ends with the interrupt enable set, a status flag is raised. Reading the status clears the flag.

The state machine has four states. `ST_REACQ` is the re-acquisition wait and is entered from reset and from group completion. `ST_IDLE` waits for a start. `ST_SAMPLE` is the acquisition window. `ST_CONV` is one conversion slot per enabled channel. The transitions are as follows:
- reset to `ST_REACQ`;
- `ST_REACQ` to `ST_SAMPLE` when the window ends with a start pending or present, otherwise to `ST_IDLE`;
- `ST_IDLE` to `ST_SAMPLE` on start;
- `ST_SAMPLE` to `ST_CONV` after the acquisition count;
- `ST_CONV` to `ST_CONV` for the next channel;
- `ST_CONV` to `ST_REACQ` after the last channel.

Top module: `adc_group_sequencer`

## Requirements
- R1: While reset is held, busy, hold, done and the channel-select code are 0, and all four result registers read 0.
- R2: After reset, a 20-clock acquisition period runs first. A start strobe given in the first clock after reset release is deferred, and busy rises exactly 20 clocks after release.
- R3: The mode bits select the group: u_en=0/aux_en=0 converts V,W; u_en=0/aux_en=1 converts V,W,AUX; u_en=1/aux_en=0 converts U,V,W; both set converts U,V,W,AUX. The mode is latched when the start is accepted.
- R4: Channels are converted in the fixed order U, V, W, AUX, and disabled channels are skipped. The select code is 0 for U, 1 for V and 2 for W, and the code is 0 whenever hold is low.
- R5: The auxiliary slot drives the select code 4 + aux_sel (codes 4 to 7), and its sample goes to the AUX result register.
- R6: Busy lasts exactly 20 + 40·n clocks for n converted channels, starting in the clock after the start is accepted.
- R7: Each sample d is stored as {d, 1'b0} (bit 0 zero). Registers of channels not in the group keep their previous value, and no result changes while busy is low.
- R8: A start strobe that arrives within 20 clocks after a group completes is held, and the next group begins exactly 20 clocks after completion. A start given after the interval is accepted on the next clock.
- R9: A start strobe seen while busy is ignored. It neither lengthens the group nor causes another group.
- R10: At group completion, done is set if irq_en is 1 at that clock. If irq_en is 0, done is left unchanged.
- R11: A status read (stat_rd high for one clock) clears done. If the read and a completion fall on the same clock, done ends up set.
- R12: Hold is low for the first 20 busy clocks and high for the remaining 40·n. The sample for each slot is taken in the last clock of that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Group start strobe, high for at least one clock |
| u_en_i | input | 1 | Mode bit: include channel U |
| aux_en_i | input | 1 | Mode bit: include the auxiliary slot |
| aux_sel_i | input | 2 | Auxiliary input selection (0 to 3) |
| irq_en_i | input | 1 | Completion interrupt enable |
| stat_rd_i | input | 1 | Status read strobe, clears done |
| conv_data_i | input | 11 | Converter data port, sampled in the last clock of a slot |
| busy_o | output | 1 | Group in progress |
| hold_o | output | 1 | Track/hold in hold, conversions running |
| ch_sel_o | output | 3 | Channel select code for the converter |
| done_o | output | 1 | Completion status flag |
| res_u_o | output | 12 | Result register U |
| res_v_o | output | 12 | Result register V |
| res_w_o | output | 12 | Result register W |
| res_aux_o | output | 12 | Result register AUX |

## Verification
Two pairs of events can meet in one clock. In the first, a status read lands on the same edge as the group completion that sets done. The bench provokes this by driving stat_rd during the last busy clock, and it judges the result by requiring done to read 1 afterwards and 0 after a separate later read. In the second, a deferred start meets the end of the re-acquisition window. The bench provokes this by strobing start in the first clock after completion (and likewise after reset), and it requires busy to rise exactly 20 clocks later, no earlier and no later.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_REACQ  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_e;

    localparam int NUM_CH = 4;
    localparam int IDX_W  = 2;

    localparam logic [IDX_W-1:0] CH_U   = 2'd0;
    localparam logic [IDX_W-1:0] CH_V   = 2'd1;
    localparam logic [IDX_W-1:0] CH_W   = 2'd2;
    localparam logic [IDX_W-1:0] CH_AUX = 2'd3;

endpackage

// File: rtl/adc_chan_plan.sv
module adc_chan_plan
    import adc_seq_pkg::*;
(
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [IDX_W-1:0]  cur_i,
    output logic [IDX_W-1:0]  first_o,
    output logic [IDX_W-1:0]  next_o,
    output logic              last_o
);

    logic got_first;
    logic got_next;

    always_comb begin
        first_o   = '0;
        got_first = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (mask_i[i] && !got_first) begin
                first_o   = IDX_W'(i);
                got_first = 1'b1;
            end
        end
    end

    always_comb begin
        next_o   = cur_i;
        got_next = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if ((i > int'(cur_i)) && mask_i[i] && !got_next) begin
                next_o   = IDX_W'(i);
                got_next = 1'b1;
            end
        end
        last_o = !got_next;
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int RAW_W = 11,
    parameter int RES_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [RAW_W-1:0]              raw_i,
    output logic [NUM_CH-1:0][RES_W-1:0]  res_o
);

    localparam int PAD_W = RES_W - RAW_W;

    logic [RES_W-1:0] formatted;

    assign formatted = {raw_i, {PAD_W{1'b0}}};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_o[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                res_o[g] <= formatted;
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ACQ_CYCLES  = 20,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              u_en_i,
    input  logic              aux_en_i,
    input  logic [1:0]        aux_sel_i,
    input  logic              irq_en_i,
    input  logic              stat_rd_i,
    input  logic [IDX_W-1:0]  first_i,
    input  logic [IDX_W-1:0]  next_i,
    input  logic              last_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic [IDX_W-1:0]  cur_o,
    output logic [1:0]        aux_sel_o,
    output logic              busy_o,
    output logic              hold_o,
    output logic              wr_en_o,
    output logic              done_o
);

    localparam int CNT_MAX = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACQ_END  = CNT_W'(ACQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_CYCLES - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              pend_q, pend_d;
    logic [NUM_CH-1:0] mask_q, mask_d;
    logic [1:0]        sel_q, sel_d;
    logic [IDX_W-1:0]  cur_q, cur_d;
    logic              done_q, done_d;
    logic              complete;
    logic              wr_slot;

    // next-state and datapath control
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + 1'b1;
        pend_d   = pend_q;
        mask_d   = mask_q;
        sel_d    = sel_q;
        cur_d    = cur_q;
        complete = 1'b0;
        wr_slot  = 1'b0;
        unique case (state_q)
            ST_REACQ: begin
                if (start_i) begin
                    pend_d = 1'b1;
                end
                if (cnt_q == ACQ_END) begin
                    cnt_d = '0;
                    if (pend_q || start_i) begin
                        state_d = ST_SAMPLE;
                        pend_d  = 1'b0;
                        mask_d  = {aux_en_i, 1'b1, 1'b1, u_en_i};
                        sel_d   = aux_sel_i;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) begin
                    state_d = ST_SAMPLE;
                    mask_d  = {aux_en_i, 1'b1, 1'b1, u_en_i};
                    sel_d   = aux_sel_i;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == ACQ_END) begin
                    cnt_d   = '0;
                    state_d = ST_CONV;
                    cur_d   = first_i;
                end
            end
            ST_CONV: begin
                if (cnt_q == CONV_END) begin
                    cnt_d   = '0;
                    wr_slot = 1'b1;
                    if (last_i) begin
                        state_d  = ST_REACQ;
                        complete = 1'b1;
                    end else begin
                        cur_d = next_i;
                    end
                end
            end
            default: begin
                state_d = ST_REACQ;
                cnt_d   = '0;
            end
        endcase
        if (complete && irq_en_i) begin
            done_d = 1'b1;
        end else if (stat_rd_i) begin
            done_d = 1'b0;
        end else begin
            done_d = done_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REACQ;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            mask_q  <= 4'b0110;
            sel_q   <= '0;
            cur_q   <= CH_V;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            mask_q  <= mask_d;
            sel_q   <= sel_d;
            cur_q   <= cur_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == ST_SAMPLE) || (state_q == ST_CONV);
        hold_o    = (state_q == ST_CONV);
        wr_en_o   = wr_slot;
        done_o    = done_q;
        mask_o    = mask_q;
        cur_o     = cur_q;
        aux_sel_o = sel_q;
    end

endmodule

// File: rtl/adc_group_sequencer.sv
module adc_group_sequencer
    import adc_seq_pkg::*;
#(
    parameter int ACQ_CYCLES  = 20,
    parameter int CONV_CYCLES = 40,
    parameter int RAW_W       = 11,
    parameter int RES_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             u_en_i,
    input  logic             aux_en_i,
    input  logic [1:0]       aux_sel_i,
    input  logic             irq_en_i,
    input  logic             stat_rd_i,
    input  logic [RAW_W-1:0] conv_data_i,
    output logic             busy_o,
    output logic             hold_o,
    output logic [2:0]       ch_sel_o,
    output logic             done_o,
    output logic [RES_W-1:0] res_u_o,
    output logic [RES_W-1:0] res_v_o,
    output logic [RES_W-1:0] res_w_o,
    output logic [RES_W-1:0] res_aux_o
);

    logic [NUM_CH-1:0]             mask;
    logic [IDX_W-1:0]              cur;
    logic [IDX_W-1:0]              first_idx;
    logic [IDX_W-1:0]              next_idx;
    logic                          last_ch;
    logic [1:0]                    aux_sel_q;
    logic                          wr_en;
    logic [NUM_CH-1:0][RES_W-1:0]  res_all;

    adc_seq_ctrl #(
        .ACQ_CYCLES  (ACQ_CYCLES),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .u_en_i    (u_en_i),
        .aux_en_i  (aux_en_i),
        .aux_sel_i (aux_sel_i),
        .irq_en_i  (irq_en_i),
        .stat_rd_i (stat_rd_i),
        .first_i   (first_idx),
        .next_i    (next_idx),
        .last_i    (last_ch),
        .mask_o    (mask),
        .cur_o     (cur),
        .aux_sel_o (aux_sel_q),
        .busy_o    (busy_o),
        .hold_o    (hold_o),
        .wr_en_o   (wr_en),
        .done_o    (done_o)
    );

    adc_chan_plan u_plan (
        .mask_i  (mask),
        .cur_i   (cur),
        .first_o (first_idx),
        .next_o  (next_idx),
        .last_o  (last_ch)
    );

    adc_result_bank #(
        .RAW_W (RAW_W),
        .RES_W (RES_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (cur),
        .raw_i    (conv_data_i),
        .res_o    (res_all)
    );

    always_comb begin
        if (!hold_o) begin
            ch_sel_o = 3'd0;
        end else if (cur == CH_AUX) begin
            ch_sel_o = {1'b1, aux_sel_q};
        end else begin
            ch_sel_o = {1'b0, cur};
        end
    end

    assign res_u_o   = res_all[CH_U];
    assign res_v_o   = res_all[CH_V];
    assign res_w_o   = res_all[CH_W];
    assign res_aux_o = res_all[CH_AUX];

endmodule

// File: rtl/adc_group_sequencer_chk.sv
module adc_group_sequencer_chk #(
    parameter int ACQ_CYCLES  = 20,
    parameter int CONV_CYCLES = 40,
    parameter int RES_W       = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_en_i,
    input logic             stat_rd_i,
    input logic             busy_o,
    input logic             hold_o,
    input logic [2:0]       ch_sel_o,
    input logic             done_o,
    input logic [RES_W-1:0] res_u_o,
    input logic [RES_W-1:0] res_v_o,
    input logic [RES_W-1:0] res_w_o,
    input logic [RES_W-1:0] res_aux_o
);

    localparam int LEN2 = ACQ_CYCLES + 2 * CONV_CYCLES;
    localparam int LEN3 = ACQ_CYCLES + 3 * CONV_CYCLES;
    localparam int LEN4 = ACQ_CYCLES + 4 * CONV_CYCLES;

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 16'd1;
        end else begin
            run_len <= '0;
        end
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == 16'(LEN2) || run_len == 16'(LEN3) || run_len == 16'(LEN4)));

    assert_sample_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> (run_len == 16'(ACQ_CYCLES)));

    assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($fell(busy_o) && $past(irq_en_i)));

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !busy_o) |=> !done_o);

    assert_results_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable({res_u_o, res_v_o, res_w_o, res_aux_o}));

    assert_sel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |-> (ch_sel_o == 3'd0));

    assert_sel_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (ch_sel_o != 3'd3));

endmodule

bind adc_group_sequencer adc_group_sequencer_chk #(
    .ACQ_CYCLES  (ACQ_CYCLES),
    .CONV_CYCLES (CONV_CYCLES),
    .RES_W       (RES_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en_i  (irq_en_i),
    .stat_rd_i (stat_rd_i),
    .busy_o    (busy_o),
    .hold_o    (hold_o),
    .ch_sel_o  (ch_sel_o),
    .done_o    (done_o),
    .res_u_o   (res_u_o),
    .res_v_o   (res_v_o),
    .res_w_o   (res_w_o),
    .res_aux_o (res_aux_o)
);

// File: tb/adc_group_sequencer_tb.sv
module adc_group_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ACQ  = 20;
    localparam int CONV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        u_en_i = 1'b0;
    logic        aux_en_i = 1'b0;
    logic [1:0]  aux_sel_i = 2'd0;
    logic        irq_en_i = 1'b0;
    logic        stat_rd_i = 1'b0;
    logic [7:0]  base_q = 8'h00;
    logic [10:0] conv_data_i;
    logic        busy_o, hold_o, done_o;
    logic [2:0]  ch_sel_o;
    logic [11:0] res_u_o, res_v_o, res_w_o, res_aux_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [11:0] exp_res [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    // converter model: data follows the selected channel code
    assign conv_data_i = {base_q, ch_sel_o};

    adc_group_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .u_en_i      (u_en_i),
        .aux_en_i    (aux_en_i),
        .aux_sel_i   (aux_sel_i),
        .irq_en_i    (irq_en_i),
        .stat_rd_i   (stat_rd_i),
        .conv_data_i (conv_data_i),
        .busy_o      (busy_o),
        .hold_o      (hold_o),
        .ch_sel_o    (ch_sel_o),
        .done_o      (done_o),
        .res_u_o     (res_u_o),
        .res_v_o     (res_v_o),
        .res_w_o     (res_w_o),
        .res_aux_o   (res_aux_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] fmt(input logic [2:0] code);
        return {base_q, code, 1'b0};
    endfunction

    task automatic check_results(input string req);
        chk(res_u_o == exp_res[0], req, "res_u", int'(res_u_o), int'(exp_res[0]));
        chk(res_v_o == exp_res[1], req, "res_v", int'(res_v_o), int'(exp_res[1]));
        chk(res_w_o == exp_res[2], req, "res_w", int'(res_w_o), int'(exp_res[2]));
        chk(res_aux_o == exp_res[3], req, "res_aux", int'(res_aux_o), int'(exp_res[3]));
    endtask

    task automatic wait_busy_end();
        int guard = 0;
        while (busy_o && guard < 400) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // R1 reset state, R2 deferred first start after reset
    task automatic test_reset_defer();
        int k;
        rst_n = 1'b0;
        start_i = 1'b0;
        u_en_i = 1'b0;
        aux_en_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
        chk(hold_o == 1'b0, "R1", "hold in reset", int'(hold_o), 0);
        chk(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
        chk(ch_sel_o == 3'd0, "R1", "ch_sel in reset", int'(ch_sel_o), 0);
        for (int i = 0; i < 4; i++) exp_res[i] = 12'd0;
        check_results("R1");
        base_q = 8'h11;
        rst_n = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        while (!busy_o && k < 60) begin
            @(negedge clk);
            k++;
        end
        chk(k == ACQ, "R2", "clocks from reset release to busy", k, ACQ);
        wait_busy_end();
        exp_res[1] = fmt(3'd1);
        exp_res[2] = fmt(3'd2);
        check_results("R2");
        repeat (25) @(negedge clk);
    endtask

    task automatic run_group(input logic u, input logic aux, input logic [1:0] sel,
                             input logic irq, input logic [7:0] base,
                             input bit mid_start, input bit collide);
        int n_busy = 0;
        int n_hold = 0;
        int nseq = 0;
        int nexp;
        int total;
        logic [2:0] seq [4];
        logic [2:0] exp_seq [4];
        logic prev_h = 1'b0;
        logic [2:0] prev_c = 3'd0;
        nexp = 0;
        if (u) begin exp_seq[nexp] = 3'd0; nexp++; end
        exp_seq[nexp] = 3'd1; nexp++;
        exp_seq[nexp] = 3'd2; nexp++;
        if (aux) begin exp_seq[nexp] = {1'b1, sel}; nexp++; end
        total = ACQ + CONV * nexp;

        @(negedge clk);
        u_en_i = u;
        aux_en_i = aux;
        aux_sel_i = sel;
        irq_en_i = irq;
        base_q = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // mode inputs changed now must not affect the latched group (R3)
        u_en_i = ~u;
        aux_en_i = ~aux;
        aux_sel_i = ~sel;
        chk(busy_o == 1'b1, "R8", "start after window accepted next clock", int'(busy_o), 1);
        while (busy_o && n_busy < 400) begin
            n_busy++;
            if (hold_o) begin
                n_hold++;
                if (!prev_h || ch_sel_o != prev_c) begin
                    if (nseq < 4) seq[nseq] = ch_sel_o;
                    nseq++;
                end
            end
            prev_h = hold_o;
            prev_c = ch_sel_o;
            start_i   = (mid_start && n_busy == 50);
            stat_rd_i = (collide && n_busy == total);
            @(negedge clk);
        end
        start_i = 1'b0;
        stat_rd_i = 1'b0;
        chk(n_busy == total, "R6", "busy length", n_busy, total);
        chk(n_hold == CONV * nexp, "R12", "hold length", n_hold, CONV * nexp);
        chk(nseq == nexp, "R3", "channels converted", nseq, nexp);
        for (int i = 0; i < 4; i++) begin
            if (i < nexp && i < nseq) begin
                chk(seq[i] == exp_seq[i], (exp_seq[i][2] ? "R5" : "R4"),
                    $sformatf("select code in slot %0d", i), int'(seq[i]), int'(exp_seq[i]));
            end
        end
        for (int i = 0; i < nexp; i++) begin
            exp_res[exp_seq[i][2] ? 3 : int'(exp_seq[i])] = fmt(exp_seq[i]);
        end
        check_results("R7");
        chk(done_o == irq, collide ? "R11" : "R10", "done after completion",
            int'(done_o), int'(irq));
        if (mid_start) begin
            repeat (30) @(negedge clk);
            chk(busy_o == 1'b0, "R9", "no group from start while busy", int'(busy_o), 0);
        end
        if (done_o) begin
            stat_rd_i = 1'b1;
            @(negedge clk);
            stat_rd_i = 1'b0;
            chk(done_o == 1'b0, "R11", "done cleared by read", int'(done_o), 0);
        end
        repeat (25) @(negedge clk);
    endtask

    // R8 start right after completion is deferred by the re-acquisition window
    task automatic test_reacq_defer();
        int k;
        run_group(1'b0, 1'b0, 2'd0, 1'b0, 8'h5A, 1'b0, 1'b0);
        // run_group ends 25 clocks after completion; run one more group and strobe at once
        @(negedge clk);
        u_en_i = 1'b0;
        aux_en_i = 1'b0;
        base_q = 8'h66;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_busy_end();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        while (!busy_o && k < 60) begin
            @(negedge clk);
            k++;
        end
        chk(k == ACQ, "R8", "clocks from completion to deferred start", k, ACQ);
        wait_busy_end();
        exp_res[1] = fmt(3'd1);
        exp_res[2] = fmt(3'd2);
        check_results("R8");
        repeat (25) @(negedge clk);
    endtask

    initial begin
        test_reset_defer();
        run_group(1'b0, 1'b0, 2'd1, 1'b1, 8'h15, 1'b0, 1'b0);
        run_group(1'b0, 1'b1, 2'd2, 1'b0, 8'hA3, 1'b0, 1'b0);
        run_group(1'b1, 1'b0, 2'd0, 1'b1, 8'h7C, 1'b0, 1'b1);
        run_group(1'b1, 1'b1, 2'd3, 1'b1, 8'h40, 1'b1, 1'b0);
        run_group(1'b1, 1'b1, 2'd0, 1'b0, 8'hFF, 1'b0, 1'b0);
        test_reacq_defer();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule